// File: doc/BRIEF.md
# Double-precision square root unit

This block takes one binary64 floating-point operand and returns its square root, rounded in one of the four IEEE rounding directions. A single-cycle `start` pulse launches an operation. The unit then works through a radix-2 restoring digit recurrence, one root bit per clock. After a fixed number of cycles it presents the packed result together with three exception flags, and marks that cycle with a one-cycle `done` pulse.

The rounding direction is latched with the operand. There are two sources for it. An embedded per-operation field is used when all three override qualifiers are high: the operation spans the full vector width, the instruction's rounding-override bit is set, and the source is a register. In every other case the direction comes from the global control field.

Special operands take a bypass path: NaNs, infinities, zeros and negative values. They still take the same fixed latency. Subnormal operands are normalized before the recurrence starts and are reported on a dedicated flag. Trapping, flush-to-zero and denormals-are-zero handling belong to the surrounding logic.

Top module: `dp_sqrt_unit`

## Requirements
- R1: For a positive normal operand, `result` is the square root rounded by the selected mode. The mode codes are: 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R2: The mode is taken from `rc_embed` when `ovr_wide`, `ovr_bcast` and `ovr_srcreg` are all 1 at the accepting edge. Otherwise it is taken from `rc_global`.
- R3: For a positive finite nonzero operand, `flg_inexact` is 1 exactly when the true root is not representable in 53 significand bits. `flg_invalid` is 0.
- R4: A subnormal operand (exponent field 0, fraction nonzero) sets `flg_denorm`. For a positive subnormal the result is a correctly rounded normal number. `flg_denorm` is 0 for every other operand.
- R5: The following operands return 64'hFFF8_0000_0000_0000 with `flg_invalid` = 1 and `flg_inexact` = 0: a negative nonzero operand, which includes minus infinity; and a signaling NaN, meaning exponent all ones, fraction nonzero and fraction bit 51 clear.
- R6: Each of these operands is returned unchanged with no flag set: +0, -0, plus infinity, and a quiet NaN (fraction bit 51 set).
- R7: `done` is high for exactly one cycle, at the 55th rising edge after the edge that accepts `start`. `result` and the flags hold their values from one `done` to the next.
- R8: A `start` that arrives while an operation is in progress is ignored. The running operation's result is not disturbed, and no extra `done` follows.
- R9: During and after reset, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| operand | input | 64 | binary64 operand |
| rc_global | input | 2 | Global rounding-direction field |
| rc_embed | input | 2 | Per-operation rounding-direction field |
| ovr_wide | input | 1 | Operation spans the full vector width |
| ovr_bcast | input | 1 | Rounding-override bit of the instruction |
| ovr_srcreg | input | 1 | Source operand is a register |
| result | output | 64 | binary64 square root |
| done | output | 1 | One-cycle result-valid pulse |
| flg_invalid | output | 1 | Invalid-operation flag |
| flg_inexact | output | 1 | Inexact (precision) flag |
| flg_denorm | output | 1 | Denormal-operand flag |

## Verification
The bench builds the unit with its default widths: an 11-bit exponent, a 52-bit fraction, and a 54-step recurrence. These are the only values for which binary64 patterns are meaningful. With them the bench reaches the following cases: the minimum subnormal, which is the deepest normalization shift; odd and even unbiased exponents, which set the radicand alignment; significands of all ones, which carry into the exponent on round-up; and exact squares, which leave a zero remainder. The bench checks each result against an independent bit-by-bit integer square root that uses its own half-way test.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int ROOT_W  = SIG_W + 1;
    localparam int RAD_W   = 2 * ROOT_W;
    localparam int REM_W   = ROOT_W + 3;
    localparam int SEXP_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int CNT_W   = $clog2(ROOT_W + 1);
    localparam int LATENCY = ROOT_W + 1;

    localparam logic [WORD_W-1:0] DEF_QNAN =
        {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic              bypass;
        logic [WORD_W-1:0] bypass_val;
        logic              invalid;
        logic              denorm;
        logic [EXP_W-1:0]  rexp;
        logic [RAD_W-1:0]  rad;
    } prep_t;

    function automatic rmode_e pick_mode(logic [1:0] glob, logic [1:0] emb,
                                         logic w, logic b, logic s);
        return rmode_e'((w & b & s) ? emb : glob);
    endfunction

    function automatic int msb_index(logic [FRAC_W-1:0] v);
        int idx;
        idx = 0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction
endpackage

// File: rtl/dsq_prep.sv
module dsq_prep
    import dsq_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output prep_t             prep
);
    fp_t                      op;
    logic                     exp_max;
    logic                     exp_zero;
    logic                     frac_nz;
    logic                     is_sub;
    logic [SIG_W-1:0]         sig;
    logic signed [SEXP_W-1:0] e_unb;
    int                       msb;

    assign op       = operand;
    assign exp_max  = &op.exp;
    assign exp_zero = (op.exp == '0);
    assign frac_nz  = |op.frac;
    assign is_sub   = exp_zero && frac_nz;

    // significand normalisation and unbiased exponent
    always_comb begin
        msb = msb_index(op.frac);
        if (is_sub) begin
            sig   = SIG_W'({1'b0, op.frac} << (FRAC_W - msb));
            e_unb = SEXP_W'(msb - (BIAS + FRAC_W - 1));
        end else begin
            sig   = {1'b1, op.frac};
            e_unb = SEXP_W'(int'(op.exp) - BIAS);
        end
    end

    always_comb begin
        prep        = '0;
        prep.denorm = is_sub;
        if (exp_max && frac_nz) begin
            prep.bypass = 1'b1;
            if (op.frac[FRAC_W-1]) begin
                prep.bypass_val = operand;
            end else begin
                prep.bypass_val = DEF_QNAN;
                prep.invalid    = 1'b1;
            end
        end else if (exp_zero && !frac_nz) begin
            prep.bypass     = 1'b1;
            prep.bypass_val = operand;
        end else if (op.sign) begin
            prep.bypass     = 1'b1;
            prep.bypass_val = DEF_QNAN;
            prep.invalid    = 1'b1;
        end else if (exp_max) begin
            prep.bypass     = 1'b1;
            prep.bypass_val = operand;
        end else begin
            // odd exponent: radicand doubled so the halved exponent is exact
            if (e_unb[0]) prep.rad = {sig, {(RAD_W-SIG_W){1'b0}}};
            else          prep.rad = {1'b0, sig, {(RAD_W-SIG_W-1){1'b0}}};
            prep.rexp = EXP_W'((e_unb >>> 1) + SEXP_W'(BIAS));
        end
    end
endmodule

// File: rtl/dsq_recur.sv
module dsq_recur
    import dsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [RAD_W-1:0]  rad_in,
    output logic [ROOT_W-1:0] root,
    output logic              rem_nz
);
    logic [RAD_W-1:0]  rad_q;
    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [REM_W-1:0]  rem_sh;
    logic [REM_W-1:0]  trial;
    logic [REM_W-1:0]  rem_nx;
    logic              fits;

    always_comb begin
        rem_sh = {rem_q[REM_W-3:0], rad_q[RAD_W-1 -: 2]};
        trial  = REM_W'({root_q, 2'b01});
        fits   = (rem_sh >= trial);
        rem_nx = fits ? (rem_sh - trial) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (load) begin
            rad_q  <= rad_in;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step) begin
            rad_q  <= {rad_q[RAD_W-3:0], 2'b00};
            rem_q  <= rem_nx;
            root_q <= {root_q[ROOT_W-2:0], fits};
        end
    end

    assign root   = root_q;
    assign rem_nz = |rem_q;
endmodule

// File: rtl/dsq_round.sv
module dsq_round
    import dsq_pkg::*;
(
    input  logic [ROOT_W-1:0] root,
    input  logic              rem_nz,
    input  logic [EXP_W-1:0]  rexp,
    input  rmode_e            mode,
    input  logic              bypass,
    input  logic [WORD_W-1:0] bypass_val,
    output logic [WORD_W-1:0] res,
    output logic              inexact
);
    logic              guard;
    logic              lsb;
    logic              inc;
    logic [SIG_W-1:0]  mant;
    logic [SIG_W:0]    sum;
    logic [EXP_W-1:0]  exp_f;

    always_comb begin
        guard = root[0];
        lsb   = root[1];
        mant  = root[ROOT_W-1:1];
        unique case (mode)
            RM_NEAR: inc = guard & (rem_nz | lsb);
            RM_UP:   inc = guard | rem_nz;
            default: inc = 1'b0;
        endcase
        sum   = {1'b0, mant} + (SIG_W+1)'(inc);
        exp_f = rexp + EXP_W'(sum[SIG_W]);
        if (bypass) begin
            res     = bypass_val;
            inexact = 1'b0;
        end else begin
            res     = {1'b0, exp_f, sum[FRAC_W-1:0]};
            inexact = guard | rem_nz;
        end
    end
endmodule

// File: rtl/dp_sqrt_unit.sv
module dp_sqrt_unit
    import dsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] operand,
    input  logic [1:0]        rc_global,
    input  logic [1:0]        rc_embed,
    input  logic              ovr_wide,
    input  logic              ovr_bcast,
    input  logic              ovr_srcreg,
    output logic [WORD_W-1:0] result,
    output logic              done,
    output logic              flg_invalid,
    output logic              flg_inexact,
    output logic              flg_denorm
);
    state_e            state;
    logic              busy;
    logic              accept;
    logic [CNT_W-1:0]  cnt;
    prep_t             prep_c;
    prep_t             prep_q;
    rmode_e            mode_q;
    logic [ROOT_W-1:0] root;
    logic              rem_nz;
    logic [WORD_W-1:0] res_c;
    logic              inexact_c;

    assign busy   = (state != ST_IDLE);
    assign accept = start && !busy;

    dsq_prep u_prep (
        .operand (operand),
        .prep    (prep_c)
    );

    dsq_recur u_recur (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (state == ST_RUN),
        .rad_in (prep_c.rad),
        .root   (root),
        .rem_nz (rem_nz)
    );

    dsq_round u_round (
        .root       (root),
        .rem_nz     (rem_nz),
        .rexp       (prep_q.rexp),
        .mode       (mode_q),
        .bypass     (prep_q.bypass),
        .bypass_val (prep_q.bypass_val),
        .res        (res_c),
        .inexact    (inexact_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            prep_q <= '0;
            mode_q <= RM_NEAR;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_RUN;
                    cnt    <= '0;
                    prep_q <= prep_c;
                    mode_q <= pick_mode(rc_global, rc_embed, ovr_wide, ovr_bcast, ovr_srcreg);
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(ROOT_W - 1)) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result      <= '0;
            done        <= 1'b0;
            flg_invalid <= 1'b0;
            flg_inexact <= 1'b0;
            flg_denorm  <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                result      <= res_c;
                flg_invalid <= prep_q.invalid;
                flg_inexact <= inexact_c;
                flg_denorm  <= prep_q.denorm;
            end
        end
    end
endmodule

module dsq_checker
    import dsq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              flg_invalid,
    input logic              flg_inexact,
    input logic              flg_denorm
);
    logic [7:0] lat;

    always_ff @(posedge clk) begin
        if (rst)                lat <= '0;
        else if (start && !busy) lat <= 8'd1;
        else if (lat != '0)      lat <= lat + 8'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == 8'(LATENCY + 1)));
    p_single_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(flg_inexact) && $stable(flg_invalid)));
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
    p_invalid_qnan_r5: assert property (@(posedge clk) disable iff (rst)
        (done && flg_invalid) |-> (result == DEF_QNAN && !flg_inexact));
    p_special_exact_r6: assert property (@(posedge clk) disable iff (rst)
        (done && (&result[WORD_W-2:FRAC_W])) |-> !flg_inexact);
    p_denorm_normal_r4: assert property (@(posedge clk) disable iff (rst)
        (done && flg_denorm && !flg_invalid) |->
        (result[WORD_W-2:FRAC_W] != '0 && !(&result[WORD_W-2:FRAC_W])));
endmodule

bind dp_sqrt_unit dsq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .flg_invalid (flg_invalid),
    .flg_inexact (flg_inexact),
    .flg_denorm  (flg_denorm)
);

// File: tb/dp_sqrt_unit_bench.sv
`timescale 1ns/1ps
module dp_sqrt_unit_bench;
    localparam logic [63:0] QNAN = 64'hFFF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  rc_global = '0;
    logic [1:0]  rc_embed = '0;
    logic        ovr_wide = 1'b0;
    logic        ovr_bcast = 1'b0;
    logic        ovr_srcreg = 1'b0;
    logic [63:0] result;
    logic        done;
    logic        flg_invalid;
    logic        flg_inexact;
    logic        flg_denorm;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dp_sqrt_unit u_dp_sqrt_unit (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .rc_global(rc_global), .rc_embed(rc_embed),
        .ovr_wide(ovr_wide), .ovr_bcast(ovr_bcast), .ovr_srcreg(ovr_srcreg),
        .result(result), .done(done), .flg_invalid(flg_invalid),
        .flg_inexact(flg_inexact), .flg_denorm(flg_denorm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] isqrt(input logic [127:0] v);
        logic [127:0] q;
        logic [127:0] t;
        q = '0;
        for (int b = 63; b >= 0; b--) begin
            t = q | (128'd1 << b);
            if (t * t <= v) q = t;
        end
        return q;
    endfunction

    // independent model: bit-by-bit root plus explicit half-way comparison
    task automatic ref_sqrt(input logic [63:0] x, input logic [1:0] m,
                            output logic [63:0] r, output logic inv,
                            output logic inx, output logic den);
        logic [10:0]  ex;
        logic [51:0]  fr;
        logic [52:0]  s;
        logic [127:0] xr;
        logic [127:0] q;
        logic         exact;
        logic         above;
        int           e;
        int           rex;
        ex = x[62:52];
        fr = x[51:0];
        inv = 1'b0; inx = 1'b0; r = '0;
        den = (ex == 0) && (fr != 0);
        if (ex == 11'h7FF && fr != 0) begin
            if (fr[51]) r = x;
            else begin r = QNAN; inv = 1'b1; end
        end else if (ex == 0 && fr == 0) begin
            r = x;
        end else if (x[63]) begin
            r = QNAN; inv = 1'b1;
        end else if (ex == 11'h7FF) begin
            r = x;
        end else begin
            if (ex == 0) begin
                s = {1'b0, fr}; e = -1022;
                while (!s[52]) begin s = s << 1; e--; end
            end else begin
                s = {1'b1, fr}; e = int'(ex) - 1023;
            end
            if (e % 2 != 0) begin xr = {75'b0, s} << 53; e = e - 1; end
            else xr = {75'b0, s} << 52;
            q     = isqrt(xr);
            exact = (q * q == xr);
            above = ((2 * q + 1) * (2 * q + 1) < 4 * xr);
            inx   = !exact;
            if (m == 2'b00) q = q + 128'(above);
            else if (m == 2'b10) q = q + 128'(!exact);
            rex = e / 2 + 1023;
            if (q[53]) begin rex++; q = q >> 1; end
            r = {1'b0, 11'(rex), q[51:0]};
        end
    endtask

    task automatic do_op(input logic [63:0] x, input logic [1:0] rg, input logic [1:0] re,
                         input logic w, input logic b, input logic sr,
                         input string tag, input bit interfere);
        logic [63:0] er;
        logic        ei, ex, ed;
        logic [1:0]  m;
        int          n;
        int          extra;
        m = (w && b && sr) ? re : rg;
        ref_sqrt(x, m, er, ei, ex, ed);
        @(negedge clk);
        operand = x; rc_global = rg; rc_embed = re;
        ovr_wide = w; ovr_bcast = b; ovr_srcreg = sr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (done !== 1'b1 && n < 200) begin
            if (interfere && n == 10) begin
                operand = x ^ 64'h0010_0000_0000_0001; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        // done rises on the 55th edge after the accepting one: seen at negedge 56
        chk(n == 56, "R7", {tag, " latency"}, 64'(n), 64'd56);
        chk(result === er, tag, "result", result, er);
        chk(flg_invalid === ei, tag, "invalid", 64'(flg_invalid), 64'(ei));
        chk(flg_inexact === ex, tag, "inexact", 64'(flg_inexact), 64'(ex));
        chk(flg_denorm === ed, tag, "denorm", 64'(flg_denorm), 64'(ed));
        @(negedge clk);
        chk(done === 1'b0 && result === er, "R7", "pulse width and hold", result, er);
        if (interfere) begin
            extra = 0;
            for (int i = 0; i < 70; i++) begin
                @(negedge clk);
                if (done === 1'b1) extra++;
            end
            chk(extra == 0, "R8", "no done for ignored start", 64'(extra), 64'd0);
            chk(result === er, "R8", "result undisturbed", result, er);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        int          cls;
        logic [63:0] er;
        logic        ei, ex, ed;
        string       tag;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(done === 1'b0 && result === 64'd0, "R9", "reset outputs", result, 64'd0);
        chk({flg_invalid, flg_inexact, flg_denorm} === 3'b000, "R9", "reset flags",
            64'({flg_invalid, flg_inexact, flg_denorm}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && result === 64'd0, "R9", "after reset idle", result, 64'd0);

        // R1 / R3: exact square and irrational roots in every mode
        do_op(64'h4010_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R3", 0);
        do_op(64'h4000_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R1", 0);
        do_op(64'h4000_0000_0000_0000, 2'b01, 2'b00, 0, 0, 0, "R1", 0);
        do_op(64'h4000_0000_0000_0000, 2'b10, 2'b00, 0, 0, 0, "R1", 0);
        do_op(64'h4000_0000_0000_0000, 2'b11, 2'b00, 0, 0, 0, "R1", 0);
        do_op(64'h3FEF_FFFF_FFFF_FFFF, 2'b10, 2'b00, 0, 0, 0, "R1", 0);
        do_op(64'h7FEF_FFFF_FFFF_FFFF, 2'b00, 2'b00, 0, 0, 0, "R1", 0);
        // R2: embedded mode only when all three qualifiers hold
        do_op(64'h4000_0000_0000_0000, 2'b00, 2'b11, 1, 1, 1, "R2", 0);
        do_op(64'h4000_0000_0000_0000, 2'b00, 2'b11, 1, 1, 0, "R2", 0);
        do_op(64'h4000_0000_0000_0000, 2'b00, 2'b11, 0, 1, 1, "R2", 0);
        do_op(64'h4000_0000_0000_0000, 2'b11, 2'b00, 1, 0, 1, "R2", 0);
        // R4: subnormal operands
        do_op(64'h0000_0000_0000_0001, 2'b00, 2'b00, 0, 0, 0, "R4", 0);
        do_op(64'h000F_FFFF_FFFF_FFFF, 2'b10, 2'b00, 0, 0, 0, "R4", 0);
        do_op(64'h8000_0000_0000_0003, 2'b00, 2'b00, 0, 0, 0, "R4", 0);
        // R5: invalid operands
        do_op(64'hBFF0_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R5", 0);
        do_op(64'hFFF0_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R5", 0);
        do_op(64'h7FF0_0000_0000_0001, 2'b00, 2'b00, 0, 0, 0, "R5", 0);
        // R6: pass-through specials
        do_op(64'h0000_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R6", 0);
        do_op(64'h8000_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R6", 0);
        do_op(64'h7FF0_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R6", 0);
        do_op(64'h7FF8_0000_0000_1234, 2'b00, 2'b00, 0, 0, 0, "R6", 0);
        // R8: start during an operation
        do_op(64'h4022_0000_0000_0000, 2'b00, 2'b00, 0, 0, 0, "R8", 1);

        for (int k = 0; k < 250; k++) begin
            cls = int'($urandom % 8);
            x = {$urandom, $urandom};
            case (cls)
                0, 1, 2, 3: begin
                    x[63] = 1'b0;
                    if (x[62:52] == 11'h7FF || x[62:52] == 0) x[62:52] = 11'h3FF;
                end
                4: begin x[63:52] = 12'h000; if (x[51:0] == 0) x[0] = 1'b1; end
                5: begin x[63] = 1'b1; if (x[62:52] == 11'h7FF) x[62:52] = 11'h400; end
                6: ;
                default: begin x[63] = 1'b0; x[51:0] = '1; x[0] = $urandom % 2; end
            endcase
            ref_sqrt(x, 2'b00, er, ei, ex, ed);
            if (ei) tag = "R5";
            else if (ed) tag = "R4";
            else if (x[62:52] == 11'h7FF || x[62:0] == 0) tag = "R6";
            else tag = "R1";
            do_op(x, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), tag, 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule